// File: doc/BRIEF.md
# Video Status Word and Beam Position Readout

This block produces the 16-bit status word that a host sees on the video controller's control port, and it applies the side effects that a status read has on the flags it holds. Some fields come straight from live inputs: region, DMA activity, horizontal and vertical blanking, and field parity. Three fields are sticky flags. Sprite collision, sprite overflow and the frame-interrupt events set them, and a read clears them under set rules. The upper byte is a toggling bus-state byte that starts as "FIFO empty".

The block also packs the beam position into one 16-bit word. The vertical byte is in the high half and the horizontal byte in the low half. The horizontal byte can be frozen by a latch strobe, and the vertical byte can be folded for the double-resolution interlace mode. Three mode-register writes control the block: the display enable, the horizontal-latch enable and the interlace selection. It also tracks the pending flag of the two-word control-port command, because a status read cancels that flag.

Top module: `vsh_top`

## Requirements
- R1: After synchronous reset the held upper byte is 0x02, the three sticky flags are 0, no horizontal latch is held, the command-pending flag is 0 and all mode bits are 0. With all live inputs at 0, the status word therefore reads 0x0208.
- R2: The status word bits are: bit 0 region input, bit 1 DMA-active input, bit 2 hblank input, bit 3 vblank input, bit 4 odd-field input, bit 5 sprite-collision flag, bit 6 sprite-overflow flag, bit 7 frame-interrupt flag, and bits 15:8 the held upper byte (bit 9 FIFO empty, bit 8 FIFO full). Each event input sets its sticky flag at the next clock edge.
- R3: After a cycle with the read strobe high, the held upper byte is inverted and the collision and overflow flags are cleared.
- R4: A read clears the frame-interrupt flag only if the vblank input is low in the read cycle. Otherwise the flag is kept.
- R5: While the display enable (mode register 1, bit 6) is 0, bit 3 of the status word is forced to 1. R4 still uses the real vblank input.
- R6: The command-pending flag is set by a first-half strobe and cleared by a second-half strobe. A status read clears it and takes priority over both strobes.
- R7: An event input that is high in the same cycle as a read leaves its flag set after the read.
- R8: The position word is {V byte, H byte}. The H byte is the latched value while a latch is held, and bits 7:0 of the live horizontal count otherwise.
- R9: A latch strobe captures the live horizontal count only while the latch enable (mode register 0, bit 1) is 1. At any other time the strobe is ignored. A held value stays unchanged until it is released or captured again.
- R10: Writing mode register 0 with bit 1 equal to 0 releases the latch. Writing it with bit 1 equal to 1 keeps the held value.
- R11: When mode register 12 has bits 2 and 1 both set, the V byte is {V[7:1], V[8]}. Otherwise it is V[7:0].
- R12: Writes to any other register index change none of the mode bits and do not release the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_rd | input | 1 | Status read strobe; side effects apply at the clock edge |
| stat_word | output | 16 | Current status word |
| spr_hit_evt | input | 1 | Sprite collision event |
| spr_many_evt | input | 1 | Sprite overflow event |
| vint_evt | input | 1 | Frame interrupt event |
| dma_active | input | 1 | DMA busy, live |
| hblank | input | 1 | Horizontal blanking, live |
| vblank | input | 1 | Vertical blanking, live |
| odd_field | input | 1 | Odd field indicator, live |
| pal_mode | input | 1 | Region, 1 = 50 Hz |
| cmd_first | input | 1 | First command word accepted |
| cmd_second | input | 1 | Second command word accepted |
| cmd_pending | output | 1 | Command waiting for its second word |
| mode_we | input | 1 | Mode register write strobe |
| mode_idx | input | 5 | Mode register index |
| mode_wdata | input | 8 | Mode register data |
| hpos | input | H_W | Live horizontal count |
| vpos | input | V_W | Live vertical count |
| hlatch_stb | input | 1 | Horizontal latch strobe |
| hv_word | output | 16 | Packed position word |

## Verification
The hardest case to reach is a read with the display off and the vblank input low while the frame-interrupt flag is set. The returned word then shows bit 3 set, yet the flag must still clear, because R4 looks at the real vblank input and not at the forced bit. The stimulus raises the interrupt event, turns the display off through mode register 1 and reads outside blanking, and the random phase covers the other combinations. Events that coincide with a read, and latch strobes that arrive while the enable is off, also come from directed steps as well as random ones.

// File: rtl/vsh_pkg.sv
package vsh_pkg;

    localparam logic [4:0] IDX_CTRL0  = 5'd0;
    localparam logic [4:0] IDX_CTRL1  = 5'd1;
    localparam logic [4:0] IDX_MODE12 = 5'd12;

    localparam int BIT_LATCH_EN = 1;
    localparam int BIT_DISP_EN  = 6;

    localparam logic [7:0] HI_RESET = 8'h02;

    typedef struct packed {
        logic odd;
        logic vblank;
        logic hblank;
        logic dma;
        logic pal;
    } live_t;

    typedef struct packed {
        logic [7:0] bus_hi;
        logic       vint;
        logic       ovf;
        logic       coll;
    } hold_t;

    typedef struct packed {
        logic disp_en;
        logic hlatch_en;
        logic im2;
    } mode_t;

    function automatic logic [15:0] pack_status(hold_t h, live_t l, logic disp_en);
        return {h.bus_hi, h.vint, h.ovf, h.coll, l.odd,
                l.vblank | ~disp_en, l.hblank, l.dma, l.pal};
    endfunction

    function automatic logic [7:0] fold_v(logic [8:0] v, logic im2);
        return im2 ? {v[7:1], v[8]} : v[7:0];
    endfunction

endpackage

// File: rtl/vsh_mode_regs.sv
module vsh_mode_regs
    import vsh_pkg::*;
#(
    parameter int IDX_W  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output mode_t             mode,
    output logic              release_lat
);

    mode_t mode_q;

    assign release_lat = we && (idx == IDX_W'(IDX_CTRL0)) && !wdata[BIT_LATCH_EN];
    assign mode = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (we) begin
            if (idx == IDX_W'(IDX_CTRL0))  mode_q.hlatch_en <= wdata[BIT_LATCH_EN];
            if (idx == IDX_W'(IDX_CTRL1))  mode_q.disp_en   <= wdata[BIT_DISP_EN];
            if (idx == IDX_W'(IDX_MODE12)) mode_q.im2       <= wdata[2] & wdata[1];
        end
    end

    p_other_idx_r12: assert property (@(posedge clk) disable iff (rst)
        (we && idx != IDX_W'(IDX_CTRL0) && idx != IDX_W'(IDX_CTRL1)
            && idx != IDX_W'(IDX_MODE12)) |=> $stable(mode_q));

endmodule

// File: rtl/vsh_status_core.sv
module vsh_status_core
    import vsh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rd,
    input  logic        coll_evt,
    input  logic        ovf_evt,
    input  logic        vint_evt,
    input  live_t       live,
    input  logic        disp_en,
    input  logic        cmd_set,
    input  logic        cmd_clr,
    output logic [15:0] status,
    output logic        pending
);

    hold_t hold_q, hold_d;
    logic  pend_q;

    always_comb begin
        hold_d = hold_q;
        if (rd) begin
            hold_d.bus_hi = ~hold_q.bus_hi;
            hold_d.coll   = coll_evt;
            hold_d.ovf    = ovf_evt;
            hold_d.vint   = (live.vblank & hold_q.vint) | vint_evt;
        end else begin
            hold_d.coll = hold_q.coll | coll_evt;
            hold_d.ovf  = hold_q.ovf  | ovf_evt;
            hold_d.vint = hold_q.vint | vint_evt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '{bus_hi: HI_RESET, vint: 1'b0, ovf: 1'b0, coll: 1'b0};
            pend_q <= 1'b0;
        end else begin
            hold_q <= hold_d;
            if (rd)           pend_q <= 1'b0;
            else if (cmd_set) pend_q <= 1'b1;
            else if (cmd_clr) pend_q <= 1'b0;
        end
    end

    assign status  = pack_status(hold_q, live, disp_en);
    assign pending = pend_q;

    p_hi_toggle_r3: assert property (@(posedge clk) disable iff (rst)
        rd |=> status[15:8] == ~$past(status[15:8]));
    p_hi_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(status[15:8]));
    p_spr_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (rd && !coll_evt && !ovf_evt) |=> (status[6:5] == 2'b00));
    p_vint_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (rd && live.vblank && status[7]) |=> status[7]);
    p_vint_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (rd && !live.vblank && !vint_evt) |=> !status[7]);
    p_evt_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (rd && vint_evt) |=> status[7]);
    p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
        rd |=> !pending);

endmodule

// File: rtl/vsh_hv_reader.sv
module vsh_hv_reader
    import vsh_pkg::*;
#(
    parameter int H_W = 8,
    parameter int V_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [H_W-1:0] hpos,
    input  logic [V_W-1:0] vpos,
    input  logic           strobe,
    input  logic           latch_en,
    input  logic           release_lat,
    input  logic           im2,
    output logic [15:0]    hv
);

    localparam int BYTE_W = 8;

    logic              held_q;
    logic [BYTE_W-1:0] lat_q;
    logic [BYTE_W-1:0] h_byte;
    logic [BYTE_W-1:0] v_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= 1'b0;
            lat_q  <= '0;
        end else if (release_lat) begin
            held_q <= 1'b0;
        end else if (strobe && latch_en) begin
            held_q <= 1'b1;
            lat_q  <= hpos[BYTE_W-1:0];
        end
    end

    assign h_byte = held_q ? lat_q : hpos[BYTE_W-1:0];
    assign v_byte = fold_v(vpos[8:0], im2);
    assign hv     = {v_byte, h_byte};

    p_latch_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (held_q && !strobe && !release_lat) |=> (held_q && $stable(lat_q)));
    p_strobe_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (!held_q && !latch_en) |=> !held_q);
    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        release_lat |=> !held_q);

endmodule

// File: rtl/vsh_top.sv
module vsh_top
    import vsh_pkg::*;
#(
    parameter int H_W = 8,
    parameter int V_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           stat_rd,
    output logic [15:0]    stat_word,
    input  logic           spr_hit_evt,
    input  logic           spr_many_evt,
    input  logic           vint_evt,
    input  logic           dma_active,
    input  logic           hblank,
    input  logic           vblank,
    input  logic           odd_field,
    input  logic           pal_mode,
    input  logic           cmd_first,
    input  logic           cmd_second,
    output logic           cmd_pending,
    input  logic           mode_we,
    input  logic [4:0]     mode_idx,
    input  logic [7:0]     mode_wdata,
    input  logic [H_W-1:0] hpos,
    input  logic [V_W-1:0] vpos,
    input  logic           hlatch_stb,
    output logic [15:0]    hv_word
);

    mode_t mode;
    logic  release_lat;
    live_t live;

    assign live = '{odd: odd_field, vblank: vblank, hblank: hblank,
                    dma: dma_active, pal: pal_mode};

    vsh_mode_regs #(.IDX_W(5), .DATA_W(8)) u_mode (
        .clk(clk), .rst(rst), .we(mode_we), .idx(mode_idx), .wdata(mode_wdata),
        .mode(mode), .release_lat(release_lat)
    );

    vsh_status_core u_stat (
        .clk(clk), .rst(rst), .rd(stat_rd),
        .coll_evt(spr_hit_evt), .ovf_evt(spr_many_evt), .vint_evt(vint_evt),
        .live(live), .disp_en(mode.disp_en),
        .cmd_set(cmd_first), .cmd_clr(cmd_second),
        .status(stat_word), .pending(cmd_pending)
    );

    vsh_hv_reader #(.H_W(H_W), .V_W(V_W)) u_hv (
        .clk(clk), .rst(rst), .hpos(hpos), .vpos(vpos), .strobe(hlatch_stb),
        .latch_en(mode.hlatch_en), .release_lat(release_lat), .im2(mode.im2),
        .hv(hv_word)
    );

    p_disp_force_r5: assert property (@(posedge clk) disable iff (rst)
        !mode.disp_en |-> stat_word[3]);

endmodule

// File: tb/vsh_top_bench.sv
module vsh_top_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        rd, hit, many, ve, dma, hb, vb, odd, pal, c1, c2, mwe, hstb;
    logic [4:0]  midx;
    logic [7:0]  mdat, hlive;
    logic [8:0]  vlive;
    logic [15:0] stat_word, hv_word;
    logic        cmd_pending;

    vsh_top u_vsh_top (
        .clk(clk), .rst(rst), .stat_rd(rd), .stat_word(stat_word),
        .spr_hit_evt(hit), .spr_many_evt(many), .vint_evt(ve),
        .dma_active(dma), .hblank(hb), .vblank(vb), .odd_field(odd), .pal_mode(pal),
        .cmd_first(c1), .cmd_second(c2), .cmd_pending(cmd_pending),
        .mode_we(mwe), .mode_idx(midx), .mode_wdata(mdat),
        .hpos(hlive), .vpos(vlive), .hlatch_stb(hstb), .hv_word(hv_word)
    );

    int total = 0;
    int bad = 0;

    logic [7:0] m_hi, m_lq;
    logic       m_coll, m_ovf, m_vint, m_pend, m_disp, m_len, m_im2, m_lv;

    function automatic logic [15:0] exp_status();
        return {m_hi, m_vint, m_ovf, m_coll, odd, vb | ~m_disp, hb, dma, pal};
    endfunction

    function automatic logic [15:0] exp_hv();
        logic [7:0] vbyte;
        vbyte = m_im2 ? {vlive[7:1], vlive[8]} : vlive[7:0];
        return {vbyte, m_lv ? m_lq : hlive};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        {rd, hit, many, ve, dma, hb, vb, odd, pal, c1, c2, mwe, hstb} = '0;
        midx = '0; mdat = '0; hlive = '0; vlive = '0;
    endtask

    task automatic model_step();
        logic rel;
        rel = mwe && midx == 5'd0 && !mdat[1];
        if (rel) m_lv = 1'b0;
        else if (hstb && m_len) begin m_lv = 1'b1; m_lq = hlive; end
        if (rd) begin
            m_hi = ~m_hi; m_coll = hit; m_ovf = many;
            m_vint = (vb & m_vint) | ve;
            m_pend = 1'b0;
        end else begin
            m_coll |= hit; m_ovf |= many; m_vint |= ve;
            if (c1) m_pend = 1'b1; else if (c2) m_pend = 1'b0;
        end
        if (mwe) begin
            if (midx == 5'd0)  m_len  = mdat[1];
            if (midx == 5'd1)  m_disp = mdat[6];
            if (midx == 5'd12) m_im2  = mdat[2] & mdat[1];
        end
    endtask

    // inputs set by caller after a falling edge; checks, then advances one clock
    task automatic cycle();
        #2;
        chk("R2 R3 R4 R5 R7 status", stat_word, exp_status());
        chk("R8 R9 R10 R11 R12 hv", hv_word, exp_hv());
        chk("R6 pending", {15'd0, cmd_pending}, {15'd0, m_pend});
        model_step();
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_hi = 8'h02; m_lq = '0;
        {m_coll, m_ovf, m_vint, m_pend, m_disp, m_len, m_im2, m_lv} = '0;
        #1;
        chk("R1 reset status", stat_word, 16'h0208);
        chk("R1 reset pending", {15'd0, cmd_pending}, 16'd0);
        #1;

        // R2 live bits and sticky events
        idle(); pal = 1; dma = 1; hb = 1; odd = 1; hit = 1; many = 1; ve = 1; cycle();
        idle(); pal = 1; #1;
        chk("R2 sticky bits", {8'd0, stat_word[7:0]}, 16'h00E9);
        idle(); mwe = 1; midx = 5'd1; mdat = 8'h40; cycle();
        // R3 read toggles upper byte, clears sprite flags
        idle(); rd = 1; vb = 1; cycle();
        idle(); vb = 1; #1;
        chk("R3 after read", stat_word, 16'hFD88);
        chk("R4 vint kept in vblank", {15'd0, stat_word[7]}, 16'd1);
        // R5 + R4 corner: display off, vblank low, flag set
        idle(); mwe = 1; midx = 5'd1; mdat = 8'h00; cycle();
        idle(); rd = 1; #1;
        chk("R5 forced vblank bit", {14'd0, stat_word[7], stat_word[3]}, 16'd3);
        cycle();
        idle(); #1;
        chk("R4 vint cleared outside vblank", {15'd0, stat_word[7]}, 16'd0);
        // R7 event with read
        idle(); rd = 1; hit = 1; ve = 1; cycle();
        idle(); #1;
        chk("R7 events survive read", {14'd0, stat_word[7], stat_word[5]}, 16'd3);
        // R6 pending
        idle(); c1 = 1; cycle();
        idle(); #1; chk("R6 set", {15'd0, cmd_pending}, 16'd1);
        idle(); rd = 1; c1 = 1; cycle();
        idle(); #1; chk("R6 read clears", {15'd0, cmd_pending}, 16'd0);
        // R9 strobe ignored when disabled
        idle(); hlive = 8'h33; hstb = 1; cycle();
        idle(); hlive = 8'h44; #1; chk("R9 strobe ignored", hv_word, 16'h0044);
        idle(); mwe = 1; midx = 5'd0; mdat = 8'h02; cycle();
        idle(); hlive = 8'h5A; hstb = 1; cycle();
        idle(); hlive = 8'h11; #1; chk("R9 latched", hv_word, 16'h005A);
        idle(); mwe = 1; midx = 5'd0; mdat = 8'h02; cycle();
        idle(); hlive = 8'h12; #1; chk("R10 bit1 set keeps", hv_word, 16'h005A);
        idle(); mwe = 1; midx = 5'd3; mdat = 8'h00; cycle();
        idle(); hlive = 8'h13; #1; chk("R12 other index ignored", hv_word, 16'h005A);
        idle(); mwe = 1; midx = 5'd0; mdat = 8'h00; cycle();
        idle(); hlive = 8'h14; #1; chk("R10 release", hv_word, 16'h0014);
        // R11 fold
        idle(); vlive = 9'h1A4; #1; chk("R11 normal", hv_word, 16'hA400);
        idle(); mwe = 1; midx = 5'd12; mdat = 8'h06; cycle();
        idle(); vlive = 9'h1A4; #1; chk("R11 fold high bit", hv_word, 16'hA500);
        idle(); vlive = 9'h0A5; #1; chk("R11 fold low", hv_word, 16'hA400);
        idle(); mwe = 1; midx = 5'd12; mdat = 8'h04; cycle();
        idle(); vlive = 9'h0A5; #1; chk("R11 one bit only", hv_word, 16'hA500);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            idle();
            rd   = ($urandom % 4) == 0;
            hit  = ($urandom % 10) == 0;
            many = ($urandom % 10) == 0;
            ve   = ($urandom % 8) == 0;
            dma  = $urandom; hb = $urandom; vb = $urandom; odd = $urandom; pal = $urandom;
            c1   = ($urandom % 6) == 0;
            c2   = ($urandom % 6) == 0;
            hstb = ($urandom % 8) == 0;
            hlive = $urandom; vlive = $urandom;
            mwe  = ($urandom % 10) == 0;
            case ($urandom % 4)
                0: midx = 5'd0;
                1: midx = 5'd1;
                2: midx = 5'd12;
                default: midx = 5'($urandom);
            endcase
            mdat = $urandom;
            cycle();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule